// File: doc/BRIEF.md
# Per-Core Cache Coherence Agent

This block sits beside one core's private cache and keeps the coherence state (Invalid, Shared, Exclusive, Modified) of every line in a small direct-mapped tag/state store. It turns the processor's loads, stores and evictions into requests to a central coherence manager. It also answers the manager's commands and takes in the manager's grants. The cache data array, the victim choice and the manager are outside the block. When a request carries a line's payload, the data array attaches it.

The processor presents one access at a time and learns in the same cycle whether the access completed locally (hit) or must wait (stall). A request to the manager leaves on a registered message port one cycle after the cycle that caused it. Each new request carries a locally numbered transaction ID. Replies to manager Invalidates reuse the manager's own ID. Only one processor-originated transaction may be outstanding, and the processor stays stalled until it completes.

Top module: `coh_agent`

## Requirements
- R1: After reset every line is Invalid, no request is presented, the stall output is low and the first request issued carries transaction ID 0.
- R2: A load (cpu_op 0) to a present line in S, E or M raises cpu_hit in the same cycle and issues no request.
- R3: A load miss issues ReadShared (req_op 0) in the next cycle and stalls. A matching GrantS (msg_op 1) installs the line in S and a matching GrantE (msg_op 2) installs it in E.
- R4: A store (cpu_op 1) to a line in E hits, moves the line to M and issues no request. The M state shows when a later Invalidate is answered with WriteBack.
- R5: A store to a line in S issues Upgrade (req_op 2). A store to an absent line issues ReadExclusive (req_op 1). A matching GrantM (msg_op 3) installs the line in M.
- R6: An Invalidate (msg_op 0) to a line in S or E, or to a line not held, is answered in the next cycle with InvAck (req_op 4). The reply carries the Invalidate's address and ID, and the line becomes Invalid.
- R7: An Invalidate to a line in M is answered in the next cycle with WriteBack (req_op 3) under the manager's ID, and the line becomes Invalid.
- R8: An eviction (cpu_op 2) of an M line issues WriteBack with a new ID and stalls until a matching WriteBackAck (msg_op 5), after which the line is Invalid. Evicting a clean line drops it with a hit and issues no request.
- R9: A Nack (msg_op 4) matching a pending Upgrade leaves the line Invalid and issues ReadExclusive in the next cycle with the next local ID.
- R10: Local IDs advance by one for each new request. Grants, Nacks and WriteBackAcks whose ID or address differ from the pending request are ignored.
- R11: While a transaction is pending, cpu_stall is high, no processor access hits and no further request is issued.
- R12: In a cycle with an incoming message the processor access has no effect and stalls. It is taken on a later cycle.
- R13: A load or store miss whose slot (index = low IDX_W address bits) holds a different line in M stalls and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_valid_i | input | 1 | Processor access present |
| cpu_op_i | input | 2 | 0 load, 1 store, 2 evict |
| cpu_addr_i | input | ADDR_W | Line address of the access |
| cpu_hit_o | output | 1 | Access completed this cycle |
| cpu_stall_o | output | 1 | Access must wait or a transaction is pending |
| msg_valid_i | input | 1 | Manager message present |
| msg_op_i | input | 3 | 0 Invalidate, 1 GrantS, 2 GrantE, 3 GrantM, 4 Nack, 5 WriteBackAck |
| msg_addr_i | input | ADDR_W | Message line address |
| msg_tid_i | input | TID_W | Message transaction ID |
| req_valid_o | output | 1 | Outgoing message present |
| req_op_o | output | 3 | 0 ReadShared, 1 ReadExclusive, 2 Upgrade, 3 WriteBack, 4 InvAck |
| req_addr_o | output | ADDR_W | Outgoing line address |
| req_tid_o | output | TID_W | Outgoing transaction ID |

## Verification
A processor access and a manager Invalidate for the same Shared line can arrive in the same cycle, and both need the single state write port and the single request port. The bench drives both in one cycle and holds the load. It expects no hit in that cycle and an InvAck carrying the manager's ID one cycle later. It then expects the held load to replay as a fresh miss with ReadShared under the next local ID, which shows that the invalidation took effect first.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {CPU_LOAD = 2'd0, CPU_STORE = 2'd1, CPU_EVICT = 2'd2, CPU_NOP = 2'd3} cpu_op_e;
  typedef enum logic [2:0] {
    OUT_RD_SH = 3'd0, OUT_RD_EX = 3'd1, OUT_UPG = 3'd2, OUT_WB = 3'd3, OUT_INV_ACK = 3'd4
  } out_op_e;
  typedef enum logic [2:0] {
    IN_INV = 3'd0, IN_GNT_S = 3'd1, IN_GNT_E = 3'd2, IN_GNT_M = 3'd3, IN_NACK = 3'd4, IN_WB_ACK = 3'd5
  } in_op_e;
  typedef enum logic [1:0] {PK_LOAD = 2'd0, PK_STORE = 2'd1, PK_UPG = 2'd2, PK_EVICT = 2'd3} pend_kind_e;
endpackage

// File: rtl/coh_tag_store.sv
module coh_tag_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  line_st_e         wr_st_i,
  input  logic [IDX_W-1:0] a_idx_i,
  output logic [TAG_W-1:0] a_tag_o,
  output line_st_e         a_st_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [TAG_W-1:0] b_tag_o,
  output line_st_e         b_st_o
);
  localparam int LINES = 1 << IDX_W;

  line_st_e         st_v  [LINES];
  logic [TAG_W-1:0] tag_v [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e         st_q;
    logic [TAG_W-1:0] tag_q;
    logic             upd;

    assign upd = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= LS_I;
        tag_q <= '0;
      end else if (upd) begin
        st_q  <= wr_st_i;
        tag_q <= wr_tag_i;
      end
    end

    assign st_v[g]  = st_q;
    assign tag_v[g] = tag_q;
  end

  assign a_st_o  = st_v[a_idx_i];
  assign a_tag_o = tag_v[a_idx_i];
  assign b_st_o  = st_v[b_idx_i];
  assign b_tag_o = tag_v[b_idx_i];
endmodule

// File: rtl/coh_txn_track.sv
module coh_txn_track
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TID_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  pend_kind_e        start_kind_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              done_i,
  output logic              busy_o,
  output pend_kind_e        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TID_W-1:0]  tid_o,
  output logic [TID_W-1:0]  next_tid_o
);
  logic              busy_q, busy_d;
  pend_kind_e        kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [TID_W-1:0]  tid_q, tid_d, ctr_q, ctr_d;

  always_comb begin
    busy_d = busy_q;
    kind_d = kind_q;
    addr_d = addr_q;
    tid_d  = tid_q;
    ctr_d  = ctr_q;
    if (start_i) begin
      busy_d = 1'b1;
      kind_d = start_kind_i;
      addr_d = start_addr_i;
      tid_d  = ctr_q;
      ctr_d  = ctr_q + 1'b1;
    end else if (done_i) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= PK_LOAD;
      addr_q <= '0;
      tid_q  <= '0;
      ctr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      tid_q  <= tid_d;
      ctr_q  <= ctr_d;
    end
  end

  assign busy_o     = busy_q;
  assign kind_o     = kind_q;
  assign addr_o     = addr_q;
  assign tid_o      = tid_q;
  assign next_tid_o = ctr_q;
endmodule

// File: rtl/coh_agent.sv
module coh_agent
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int TID_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic [1:0]        cpu_op_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_hit_o,
  output logic              cpu_stall_o,
  input  logic              msg_valid_i,
  input  logic [2:0]        msg_op_i,
  input  logic [ADDR_W-1:0] msg_addr_i,
  input  logic [TID_W-1:0]  msg_tid_i,
  output logic              req_valid_o,
  output logic [2:0]        req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [TID_W-1:0]  req_tid_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  // reset: asserted asynchronously, released on the clock
  logic rs0_q, rs1_q, rst_n_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_n_s = rs1_q;

  logic [IDX_W-1:0] c_idx, m_idx, wr_idx;
  logic [TAG_W-1:0] c_tag, m_tag, a_tag, b_tag, wr_tag;
  line_st_e         c_st, m_st, wr_st, gnt_st;
  logic             wr_en;

  assign c_idx = cpu_addr_i[IDX_W-1:0];
  assign c_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign m_idx = msg_addr_i[IDX_W-1:0];
  assign m_tag = msg_addr_i[ADDR_W-1:IDX_W];

  coh_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_tag_i (wr_tag),
    .wr_st_i  (wr_st),
    .a_idx_i  (c_idx),
    .a_tag_o  (a_tag),
    .a_st_o   (c_st),
    .b_idx_i  (m_idx),
    .b_tag_o  (b_tag),
    .b_st_o   (m_st)
  );

  logic              t_start, t_done, busy;
  pend_kind_e        t_kind, p_kind;
  logic [ADDR_W-1:0] t_addr, p_addr;
  logic [TID_W-1:0]  p_tid, nxt_tid;

  coh_txn_track #(.ADDR_W(ADDR_W), .TID_W(TID_W)) u_txn (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .start_i      (t_start),
    .start_kind_i (t_kind),
    .start_addr_i (t_addr),
    .done_i       (t_done),
    .busy_o       (busy),
    .kind_o       (p_kind),
    .addr_o       (p_addr),
    .tid_o        (p_tid),
    .next_tid_o   (nxt_tid)
  );

  logic c_present, c_victim_dirty, m_present, p_match, hit;
  assign c_present      = (c_st != LS_I) && (a_tag == c_tag);
  assign c_victim_dirty = (c_st == LS_M) && (a_tag != c_tag);
  assign m_present      = (m_st != LS_I) && (b_tag == m_tag);
  assign p_match        = busy && (msg_tid_i == p_tid) && (msg_addr_i == p_addr);

  always_comb begin
    case (in_op_e'(msg_op_i))
      IN_GNT_S: gnt_st = LS_S;
      IN_GNT_E: gnt_st = LS_E;
      default:  gnt_st = LS_M;
    endcase
  end

  logic              o_v;
  out_op_e           o_op;
  logic [ADDR_W-1:0] o_addr;
  logic [TID_W-1:0]  o_tid;

  // next-state decision: manager messages take precedence over the processor
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = c_idx;
    wr_tag  = c_tag;
    wr_st   = LS_I;
    t_start = 1'b0;
    t_kind  = PK_LOAD;
    t_addr  = cpu_addr_i;
    t_done  = 1'b0;
    o_v     = 1'b0;
    o_op    = OUT_RD_SH;
    o_addr  = cpu_addr_i;
    o_tid   = nxt_tid;
    hit     = 1'b0;
    if (msg_valid_i) begin
      wr_idx = m_idx;
      wr_tag = m_tag;
      o_addr = msg_addr_i;
      case (in_op_e'(msg_op_i))
        IN_INV: begin
          o_v   = 1'b1;
          o_tid = msg_tid_i;
          o_op  = (m_present && m_st == LS_M) ? OUT_WB : OUT_INV_ACK;
          wr_en = m_present;
        end
        IN_GNT_S, IN_GNT_E, IN_GNT_M: begin
          if (p_match && p_kind != PK_EVICT) begin
            wr_en  = 1'b1;
            wr_st  = gnt_st;
            t_done = 1'b1;
          end
        end
        IN_NACK: begin
          if (p_match && p_kind == PK_UPG) begin
            wr_en   = m_present;
            t_start = 1'b1;
            t_kind  = PK_STORE;
            t_addr  = msg_addr_i;
            o_v     = 1'b1;
            o_op    = OUT_RD_EX;
          end
        end
        IN_WB_ACK: begin
          if (p_match && p_kind == PK_EVICT) begin
            wr_en  = m_present;
            t_done = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (cpu_valid_i && !busy) begin
      case (cpu_op_e'(cpu_op_i))
        CPU_LOAD: begin
          if (c_present) begin
            hit = 1'b1;
          end else if (!c_victim_dirty) begin
            t_start = 1'b1;
            t_kind  = PK_LOAD;
            o_v     = 1'b1;
            o_op    = OUT_RD_SH;
          end
        end
        CPU_STORE: begin
          if (c_present && c_st == LS_S) begin
            t_start = 1'b1;
            t_kind  = PK_UPG;
            o_v     = 1'b1;
            o_op    = OUT_UPG;
          end else if (c_present) begin
            hit   = 1'b1;
            wr_en = (c_st == LS_E);
            wr_st = LS_M;
          end else if (!c_victim_dirty) begin
            t_start = 1'b1;
            t_kind  = PK_STORE;
            o_v     = 1'b1;
            o_op    = OUT_RD_EX;
          end
        end
        CPU_EVICT: begin
          if (c_present && c_st == LS_M) begin
            t_start = 1'b1;
            t_kind  = PK_EVICT;
            o_v     = 1'b1;
            o_op    = OUT_WB;
          end else begin
            hit   = 1'b1;
            wr_en = c_present;
          end
        end
        default: hit = 1'b1;
      endcase
    end
  end

  logic              rq_v_q;
  logic [2:0]        rq_op_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [TID_W-1:0]  rq_tid_q;

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rq_v_q    <= 1'b0;
      rq_op_q   <= '0;
      rq_addr_q <= '0;
      rq_tid_q  <= '0;
    end else begin
      rq_v_q <= o_v;
      if (o_v) begin
        rq_op_q   <= o_op;
        rq_addr_q <= o_addr;
        rq_tid_q  <= o_tid;
      end
    end
  end

  assign cpu_hit_o   = hit;
  assign cpu_stall_o = busy | (cpu_valid_i & ~hit);
  assign req_valid_o = rq_v_q;
  assign req_op_o    = rq_op_q;
  assign req_addr_o  = rq_addr_q;
  assign req_tid_o   = rq_tid_q;
endmodule

// File: rtl/coh_agent_chk.sv
module coh_agent_chk
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TID_W  = 4
) (
  input logic              clk_i,
  input logic              rst_n_s,
  input logic              cpu_valid_i,
  input logic [1:0]        cpu_op_i,
  input logic              cpu_hit_o,
  input logic              cpu_stall_o,
  input logic              msg_valid_i,
  input logic [2:0]        msg_op_i,
  input logic [ADDR_W-1:0] msg_addr_i,
  input logic [TID_W-1:0]  msg_tid_i,
  input logic              req_valid_o,
  input logic [2:0]        req_op_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [TID_W-1:0]  req_tid_o,
  input logic              busy,
  input pend_kind_e        p_kind,
  input logic [ADDR_W-1:0] p_addr,
  input logic [TID_W-1:0]  p_tid
);
  // R6
  inv_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    msg_valid_i && msg_op_i == IN_INV |=> req_valid_o && req_tid_o == $past(msg_tid_i)
      && req_addr_o == $past(msg_addr_i) && (req_op_o == OUT_INV_ACK || req_op_o == OUT_WB));

  // R12
  msg_blocks_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    msg_valid_i |-> !cpu_hit_o);

  // R9
  nack_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    msg_valid_i && msg_op_i == IN_NACK && busy && p_kind == PK_UPG && msg_tid_i == p_tid
      && msg_addr_i == p_addr |=> req_valid_o && req_op_o == OUT_RD_EX
      && req_tid_o == TID_W'($past(p_tid) + 1'b1));

  // R3
  rdsh_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    req_valid_o && req_op_o == OUT_RD_SH |-> $past(cpu_valid_i && cpu_op_i == CPU_LOAD && !msg_valid_i));

  // R11
  one_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    busy && !msg_valid_i |=> !req_valid_o);

  // R11
  stall_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    req_valid_o && req_op_o == OUT_RD_SH |-> cpu_stall_o);
endmodule

bind coh_agent coh_agent_chk #(.ADDR_W(ADDR_W), .TID_W(TID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n_s     (rst_n_s),
  .cpu_valid_i (cpu_valid_i),
  .cpu_op_i    (cpu_op_i),
  .cpu_hit_o   (cpu_hit_o),
  .cpu_stall_o (cpu_stall_o),
  .msg_valid_i (msg_valid_i),
  .msg_op_i    (msg_op_i),
  .msg_addr_i  (msg_addr_i),
  .msg_tid_i   (msg_tid_i),
  .req_valid_o (req_valid_o),
  .req_op_o    (req_op_o),
  .req_addr_o  (req_addr_o),
  .req_tid_o   (req_tid_o),
  .busy        (busy),
  .p_kind      (p_kind),
  .p_addr      (p_addr),
  .p_tid       (p_tid)
);

// File: tb/tb_coh_agent.sv
module tb_coh_agent;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam int TW = 4;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, EV = 2'd2;
  localparam logic [2:0] Q_RS = 3'd0, Q_RX = 3'd1, Q_UP = 3'd2, Q_WB = 3'd3, Q_IA = 3'd4;
  localparam logic [2:0] M_INV = 3'd0, M_GS = 3'd1, M_GE = 3'd2, M_GM = 3'd3, M_NK = 3'd4, M_WA = 3'd5;

  logic clk, rst_n;
  logic c_valid, c_hit, c_stall, m_valid, r_valid;
  logic [1:0] c_op;
  logic [2:0] m_op, r_op;
  logic [AW-1:0] c_addr, m_addr, r_addr;
  logic [TW-1:0] m_tid, r_tid;

  int nchk = 0;
  int nfail = 0;
  logic [TW-1:0] ntid;

  coh_agent #(.ADDR_W(AW), .IDX_W(IW), .TID_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(c_valid), .cpu_op_i(c_op), .cpu_addr_i(c_addr),
    .cpu_hit_o(c_hit), .cpu_stall_o(c_stall),
    .msg_valid_i(m_valid), .msg_op_i(m_op), .msg_addr_i(m_addr), .msg_tid_i(m_tid),
    .req_valid_o(r_valid), .req_op_o(r_op), .req_addr_o(r_addr), .req_tid_o(r_tid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] ad(input int t, input int i);
    logic [3:0] tt = 4'(t);
    logic [1:0] ii = 2'(i);
    return {tt, ii};
  endfunction

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic chk_req(input bit exp_v, input logic [2:0] exp_op, input logic [AW-1:0] exp_a,
                         input logic [TW-1:0] exp_t, input string rq);
    check(r_valid == exp_v, rq, "req_valid", int'(r_valid), int'(exp_v));
    if (exp_v) begin
      check(r_op == exp_op, rq, "req_op", int'(r_op), int'(exp_op));
      check(r_addr == exp_a, rq, "req_addr", int'(r_addr), int'(exp_a));
      check(r_tid == exp_t, rq, "req_tid", int'(r_tid), int'(exp_t));
    end
  endtask

  // processor access; a new request must carry the next local ID
  task automatic cpu(input logic [1:0] op, input logic [AW-1:0] a, input bit exp_hit,
                     input bit exp_req, input logic [2:0] exp_op, input string rq);
    @(negedge clk);
    c_valid = 1'b1; c_op = op; c_addr = a;
    #1;
    check(c_hit == exp_hit, rq, "cpu_hit", int'(c_hit), int'(exp_hit));
    check(c_stall == !exp_hit, rq, "cpu_stall", int'(c_stall), int'(!exp_hit));
    @(negedge clk);
    c_valid = 1'b0;
    chk_req(exp_req, exp_op, a, ntid, rq);
    if (exp_req) ntid = ntid + 1'b1;
  endtask

  task automatic msg(input logic [2:0] op, input logic [AW-1:0] a, input logic [TW-1:0] t,
                     input bit exp_req, input logic [2:0] exp_op, input logic [TW-1:0] exp_t,
                     input string rq);
    @(negedge clk);
    m_valid = 1'b1; m_op = op; m_addr = a; m_tid = t;
    @(negedge clk);
    m_valid = 1'b0;
    chk_req(exp_req, exp_op, a, exp_t, rq);
  endtask

  task automatic stall_is(input bit exp, input string rq);
    @(negedge clk);
    #1;
    check(c_stall == exp, rq, "stall", int'(c_stall), int'(exp));
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [TW-1:0] t0;
    logic [AW-1:0] a, b;
    rst_n = 1'b0; c_valid = 1'b0; c_op = '0; c_addr = '0;
    m_valid = 1'b0; m_op = '0; m_addr = '0; m_tid = '0; ntid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(r_valid == 1'b0, "R1", "req_valid", int'(r_valid), 0);
    check(c_stall == 1'b0, "R1", "stall", int'(c_stall), 0);

    // sweep every slot through the main state paths
    for (int i = 0; i < 4; i++) begin
      a = ad(i + 1, i);
      t0 = ntid;
      cpu(LD, a, 1'b0, 1'b1, Q_RS, "R3");                        // R1 first one has ID 0
      stall_is(1'b1, "R11");
      cpu(LD, ad(9, i + 1), 1'b0, 1'b0, Q_RS, "R11");            // blocked while pending
      msg((i % 2 == 0) ? M_GS : M_GE, a, t0 + 1'b1, 1'b0, Q_RS, '0, "R10");
      stall_is(1'b1, "R10");
      msg((i % 2 == 0) ? M_GS : M_GE, a, t0, 1'b0, Q_RS, '0, "R3");
      stall_is(1'b0, "R3");
      cpu(LD, a, 1'b1, 1'b0, Q_RS, "R2");
      if (i % 2 == 0) begin
        t0 = ntid;
        cpu(ST, a, 1'b0, 1'b1, Q_UP, "R5");
        msg(M_GM, a, t0, 1'b0, Q_RS, '0, "R5");
      end else begin
        cpu(ST, a, 1'b1, 1'b0, Q_RS, "R4");
      end
      cpu(ST, a, 1'b1, 1'b0, Q_RS, "R5");
      msg(M_INV, a, 4'd9, 1'b1, Q_WB, 4'd9, "R7");
      t0 = ntid;
      cpu(LD, a, 1'b0, 1'b1, Q_RS, "R6");
      msg(M_GE, a, t0, 1'b0, Q_RS, '0, "R3");
      cpu(ST, a, 1'b1, 1'b0, Q_RS, "R4");
      t0 = ntid;
      cpu(EV, a, 1'b0, 1'b1, Q_WB, "R8");
      stall_is(1'b1, "R8");
      msg(M_WA, a, t0 + 4'd3, 1'b0, Q_RS, '0, "R10");
      stall_is(1'b1, "R10");
      msg(M_WA, a, t0, 1'b0, Q_RS, '0, "R8");
      stall_is(1'b0, "R8");
      t0 = ntid;
      cpu(LD, a, 1'b0, 1'b1, Q_RS, "R8");
      msg(M_GS, a, t0, 1'b0, Q_RS, '0, "R3");
      msg(M_INV, a, 4'd5, 1'b1, Q_IA, 4'd5, "R6");
      cpu(EV, a, 1'b1, 1'b0, Q_RS, "R8");
    end

    // R6 invalidate for a line never held
    msg(M_INV, ad(12, 3), 4'd2, 1'b1, Q_IA, 4'd2, "R6");

    // R13 dirty victim blocks a conflicting miss
    a = ad(1, 0); b = ad(6, 0);
    t0 = ntid;
    cpu(ST, a, 1'b0, 1'b1, Q_RX, "R5");
    msg(M_GE, a, t0, 1'b0, Q_RS, '0, "R5");
    cpu(ST, a, 1'b1, 1'b0, Q_RS, "R4");
    cpu(LD, b, 1'b0, 1'b0, Q_RS, "R13");
    cpu(ST, b, 1'b0, 1'b0, Q_RS, "R13");
    t0 = ntid;
    cpu(EV, a, 1'b0, 1'b1, Q_WB, "R8");
    msg(M_WA, a, t0, 1'b0, Q_RS, '0, "R8");
    t0 = ntid;
    cpu(LD, b, 1'b0, 1'b1, Q_RS, "R13");
    msg(M_GS, b, t0, 1'b0, Q_RS, '0, "R3");
    cpu(EV, b, 1'b1, 1'b0, Q_RS, "R8");
    t0 = ntid;
    cpu(LD, b, 1'b0, 1'b1, Q_RS, "R8");
    msg(M_GS, b, t0, 1'b0, Q_RS, '0, "R3");

    // R9 upgrade loses to an invalidate, then is refused
    t0 = ntid;
    cpu(ST, b, 1'b0, 1'b1, Q_UP, "R5");
    msg(M_INV, b, 4'd11, 1'b1, Q_IA, 4'd11, "R6");
    msg(M_NK, b, t0 + 4'd7, 1'b0, Q_RS, '0, "R10");
    msg(M_NK, b, t0, 1'b1, Q_RX, ntid, "R9");
    t0 = ntid; ntid = ntid + 1'b1;
    stall_is(1'b1, "R9");
    msg(M_GM, b, t0, 1'b0, Q_RS, '0, "R9");
    cpu(ST, b, 1'b1, 1'b0, Q_RS, "R5");
    msg(M_INV, b, 4'd1, 1'b1, Q_WB, 4'd1, "R7");

    // R12 processor load and invalidate in the same cycle
    a = ad(2, 1);
    t0 = ntid;
    cpu(LD, a, 1'b0, 1'b1, Q_RS, "R3");
    msg(M_GS, a, t0, 1'b0, Q_RS, '0, "R3");
    @(negedge clk);
    c_valid = 1'b1; c_op = LD; c_addr = a;
    m_valid = 1'b1; m_op = M_INV; m_addr = a; m_tid = 4'd13;
    #1;
    check(c_hit == 1'b0, "R12", "cpu_hit", int'(c_hit), 0);
    check(c_stall == 1'b1, "R12", "cpu_stall", int'(c_stall), 1);
    @(negedge clk);
    m_valid = 1'b0;
    chk_req(1'b1, Q_IA, a, 4'd13, "R12");
    @(negedge clk);
    c_valid = 1'b0;
    chk_req(1'b1, Q_RS, a, ntid, "R12");
    t0 = ntid; ntid = ntid + 1'b1;
    msg(M_GS, a, t0, 1'b0, Q_RS, '0, "R3");
    cpu(LD, a, 1'b1, 1'b0, Q_RS, "R2");

    finish_run();
  end
endmodule